// File: doc/BRIEF.md
# Genlock Source Selector

This block watches a reference composite sync input that pulses low, sampled on a free-running local clock. From that input it decides whether the sync chain should follow the reference (genlock) or run from its own local timebase (stand-alone). It has three outputs. A mode flag picks the timebase. A horizontal phase-reset strobe marks reference edges that arrive at full line spacing. A vertical reset strobe marks the start of the reference's vertical sync.

Presence of the reference is judged from the spacing of its falling edges. Each edge must arrive at a nominal line or half-line interval, within a ten percent tolerance. Absence is judged from a long gap with no falling edge at all. When the reference goes away, the mode flag holds for a programmable hold-off before it drops back to stand-alone. Vertical sync is found by measuring the width of each low pulse, so no analog integrator is needed. A separate input forces stand-alone operation.

All timing is in local clock cycles and follows from LINE_CYC (the nominal line period, default 64). The half-line period is LINE_CYC/2. The line tolerance is LINE_CYC/10 and the half-line tolerance is (LINE_CYC/2)/10. The loss gap is LOSS_LINES×LINE_CYC. The broad-pulse threshold is LINE_CYC/4+1.

Top module: `genlock_source_select`

## Requirements
- R1: While rstN is low, and right after it is released, genlockMode, hPhaseStrobe and vResetStrobe are all 0.
- R2: In stand-alone mode, genlockMode rises one cycle after the LOCK_EDGES-th consecutive falling edge of refSyncN whose spacing from the previous falling edge lies within LINE_CYC±LINE_CYC/10 or LINE_CYC/2±(LINE_CYC/2)/10 cycles. An edge whose spacing falls outside both windows restarts the count at zero.
- R3: While forceLocal is 1, genlockMode is 0 from the next cycle on, no strobe is issued, and the edge count is cleared.
- R4: In genlock mode, a falling edge spaced LINE_CYC±LINE_CYC/10 cycles from the previous falling edge produces a one-cycle hPhaseStrobe in the cycle after the edge is sampled. Edges at half-line spacing, edges outside tolerance, and the edge that completes lock produce none.
- R5: After LOSS_LINES×LINE_CYC cycles without a falling edge, genlockMode stays 1 for HOLD_CYC further cycles and then returns to 0.
- R6: A low pulse is broad when it lasts at least LINE_CYC/4+1 cycles. A shorter low pulse ends any run of broad pulses.
- R7: In genlock mode, vResetStrobe is a one-cycle pulse in the cycle after the end of the second consecutive broad pulse. It is issued only once per run of broad pulses, and a single isolated broad pulse gives none.
- R8: Neither strobe is ever 1 while genlockMode is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running local sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| forceLocal | input | 1 | 1 forces stand-alone operation |
| refSyncN | input | 1 | Reference composite sync, low-going pulses, idle high |
| genlockMode | output | 1 | 1 selects the reference timebase, 0 the local one |
| hPhaseStrobe | output | 1 | One-cycle horizontal phase reset |
| vResetStrobe | output | 1 | One-cycle vertical reset |

## Verification
Two things can land on the same sampled edge. Lock can complete on an edge that is also at full line spacing, which would qualify it for a horizontal strobe, and the rule is that it does not get one. The bench locks onto line-spaced pulses and counts strobes across the locking sequence, where it expects none, and then checks that the very next edge does strobe. Broad-pulse ends and line edges also meet in one waveform when broad pulses come at full line spacing. There the bench counts both strobes for every pulse window and judges each against its own expected count.

// File: rtl/gensel_pkg.sv
package gensel_pkg;

  // Events decoded from the reference input, valid for the current cycle
  typedef struct packed {
    logic fall;       // falling edge sampled this cycle
    logic lineGap;    // falling edge at full-line spacing
    logic halfGap;    // falling edge at half-line spacing
    logic noRef;      // no falling edge for the loss window
    logic broadEnd;   // a broad low pulse just ended
    logic narrowEnd;  // a short low pulse just ended
  } refEvt_t;

  typedef enum logic [1:0] {
    ST_LOCAL  = 2'd0,
    ST_LOCKED = 2'd1,
    ST_HOLD   = 2'd2
  } modeState_t;

endpackage

// File: rtl/gensel_measure.sv
module gensel_measure
  import gensel_pkg::*;
#(
  parameter int LINE_CYC   = 64,
  parameter int LOSS_LINES = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    refSyncN,
  output refEvt_t evt
);

  localparam int HALF_CYC  = LINE_CYC / 2;
  localparam int LINE_TOL  = LINE_CYC / 10;
  localparam int HALF_TOL  = HALF_CYC / 10;
  localparam int LOSS_CYC  = LINE_CYC * LOSS_LINES;
  localparam int BROAD_MIN = LINE_CYC / 4 + 1;
  localparam int GAP_W     = $clog2(LOSS_CYC + 1);
  localparam int LOW_W     = $clog2(BROAD_MIN + 1);

  logic             prevLevel;
  logic [GAP_W-1:0] gapCnt;
  logic [LOW_W-1:0] lowCnt;
  logic             fallNow;
  logic             riseNow;

  assign fallNow = prevLevel & ~refSyncN;
  assign riseNow = ~prevLevel & refSyncN;

  // gapCnt holds the spacing to the previous fall when a new fall is seen
  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevLevel <= 1'b1;
      gapCnt    <= GAP_W'(LOSS_CYC);
      lowCnt    <= '0;
    end else begin
      prevLevel <= refSyncN;
      if (fallNow)
        gapCnt <= GAP_W'(1);
      else if (gapCnt != GAP_W'(LOSS_CYC))
        gapCnt <= gapCnt + GAP_W'(1);
      if (refSyncN)
        lowCnt <= '0;
      else if (lowCnt != LOW_W'(BROAD_MIN))
        lowCnt <= lowCnt + LOW_W'(1);
    end
  end

  always_comb begin
    evt           = '0;
    evt.fall      = fallNow;
    evt.lineGap   = fallNow && (gapCnt >= GAP_W'(LINE_CYC - LINE_TOL))
                            && (gapCnt <= GAP_W'(LINE_CYC + LINE_TOL));
    evt.halfGap   = fallNow && (gapCnt >= GAP_W'(HALF_CYC - HALF_TOL))
                            && (gapCnt <= GAP_W'(HALF_CYC + HALF_TOL));
    evt.noRef     = (gapCnt == GAP_W'(LOSS_CYC));
    evt.broadEnd  = riseNow && (lowCnt == LOW_W'(BROAD_MIN));
    evt.narrowEnd = riseNow && (lowCnt != LOW_W'(BROAD_MIN));
  end

endmodule

// File: rtl/gensel_ctrl.sv
module gensel_ctrl
  import gensel_pkg::*;
#(
  parameter int LOCK_EDGES = 8,
  parameter int HOLD_CYC   = 100
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    forceLocal,
  input  refEvt_t evt,
  output logic    genlockMode,
  output logic    hPhaseStrobe,
  output logic    vResetStrobe
);

  localparam int LOCK_W = $clog2(LOCK_EDGES + 1);
  localparam int HOLD_W = $clog2(HOLD_CYC + 1);

  modeState_t        state;
  logic [LOCK_W-1:0] lockCnt;
  logic [LOCK_W-1:0] lockNxt;
  logic [HOLD_W-1:0] holdCnt;
  logic [1:0]        broadRun;
  logic              goodEdge;
  logic              lockHit;
  logic              locked;

  assign goodEdge = evt.lineGap | evt.halfGap;
  assign locked   = (state == ST_LOCKED);
  assign lockHit  = (lockNxt == LOCK_W'(LOCK_EDGES));

  always_comb begin
    lockNxt = lockCnt;
    if (evt.fall) begin
      if (!goodEdge)
        lockNxt = '0;
      else if (lockCnt != LOCK_W'(LOCK_EDGES))
        lockNxt = lockCnt + LOCK_W'(1);
    end else if (evt.noRef) begin
      lockNxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || forceLocal) begin
      state        <= ST_LOCAL;
      lockCnt      <= '0;
      holdCnt      <= '0;
      broadRun     <= '0;
      hPhaseStrobe <= 1'b0;
      vResetStrobe <= 1'b0;
    end else begin
      lockCnt      <= lockNxt;
      hPhaseStrobe <= locked & evt.lineGap;
      vResetStrobe <= locked & evt.broadEnd & (broadRun == 2'd1);

      if (evt.noRef)
        broadRun <= '0;
      else if (evt.broadEnd && broadRun != 2'd2)
        broadRun <= broadRun + 2'd1;
      else if (evt.narrowEnd)
        broadRun <= '0;

      unique case (state)
        ST_LOCAL: begin
          if (lockHit) state <= ST_LOCKED;
        end
        ST_LOCKED: begin
          if (evt.noRef) begin
            state   <= ST_HOLD;
            holdCnt <= '0;
          end
        end
        ST_HOLD: begin
          if (lockHit)
            state <= ST_LOCKED;
          else if (holdCnt == HOLD_W'(HOLD_CYC - 1))
            state <= ST_LOCAL;
          else
            holdCnt <= holdCnt + HOLD_W'(1);
        end
        default: state <= ST_LOCAL;
      endcase
    end
  end

  assign genlockMode = (state != ST_LOCAL);

endmodule

// File: rtl/genlock_source_select.sv
module genlock_source_select
  import gensel_pkg::*;
#(
  parameter int LINE_CYC   = 64,
  parameter int LOSS_LINES = 4,
  parameter int LOCK_EDGES = 8,
  parameter int HOLD_CYC   = 100
) (
  input  logic clk,
  input  logic rstN,
  input  logic forceLocal,
  input  logic refSyncN,
  output logic genlockMode,
  output logic hPhaseStrobe,
  output logic vResetStrobe
);

  refEvt_t evt;

  gensel_measure #(
    .LINE_CYC  (LINE_CYC),
    .LOSS_LINES(LOSS_LINES)
  ) u_measure (
    .clk     (clk),
    .rstN    (rstN),
    .refSyncN(refSyncN),
    .evt     (evt)
  );

  gensel_ctrl #(
    .LOCK_EDGES(LOCK_EDGES),
    .HOLD_CYC  (HOLD_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .forceLocal  (forceLocal),
    .evt         (evt),
    .genlockMode (genlockMode),
    .hPhaseStrobe(hPhaseStrobe),
    .vResetStrobe(vResetStrobe)
  );

endmodule

// File: rtl/gensel_checker.sv
module gensel_checker (
  input logic clk,
  input logic rstN,
  input logic forceLocal,
  input logic refSyncN,
  input logic genlockMode,
  input logic hPhaseStrobe,
  input logic vResetStrobe
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!genlockMode && !hPhaseStrobe && !vResetStrobe)); // R1

  AST_FORCE_LOCAL: assert property (@(posedge clk) disable iff (!rstN)
    forceLocal |=> (!genlockMode && !hPhaseStrobe && !vResetStrobe)); // R3

  AST_H_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    hPhaseStrobe |-> (!$past(refSyncN) && $past(refSyncN, 2))); // R4

  AST_H_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    hPhaseStrobe |=> !hPhaseStrobe); // R4

  AST_V_AFTER_RISE: assert property (@(posedge clk) disable iff (!rstN)
    vResetStrobe |-> ($past(refSyncN) && !$past(refSyncN, 2))); // R7

  AST_V_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    vResetStrobe |=> !vResetStrobe); // R7

  AST_STROBE_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    (hPhaseStrobe || vResetStrobe) |-> genlockMode); // R8

endmodule

bind genlock_source_select gensel_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .forceLocal  (forceLocal),
  .refSyncN    (refSyncN),
  .genlockMode (genlockMode),
  .hPhaseStrobe(hPhaseStrobe),
  .vResetStrobe(vResetStrobe)
);

// File: tb/tb_genlock_source_select.sv
module tb_genlock_source_select;

  localparam int LINE = 64;
  localparam int LOSS = 4 * LINE;
  localparam int HOLD = 100;

  typedef struct packed {
    logic [7:0] period;
    logic [7:0] low;
    logic       expH;
    logic       expV;
  } vec_t;

  // Applied after lock; expH depends on the previous entry's period
  localparam vec_t VECS [38] = '{
    '{8'd64, 8'd5,  1'b1, 1'b0}, '{8'd64, 8'd5,  1'b1, 1'b0},
    '{8'd32, 8'd2,  1'b1, 1'b0}, '{8'd32, 8'd2,  1'b0, 1'b0},
    '{8'd32, 8'd2,  1'b0, 1'b0}, '{8'd32, 8'd2,  1'b0, 1'b0},
    '{8'd32, 8'd2,  1'b0, 1'b0}, '{8'd32, 8'd2,  1'b0, 1'b0},
    '{8'd32, 8'd27, 1'b0, 1'b0}, '{8'd32, 8'd27, 1'b0, 1'b1},
    '{8'd32, 8'd27, 1'b0, 1'b0}, '{8'd32, 8'd27, 1'b0, 1'b0},
    '{8'd32, 8'd27, 1'b0, 1'b0}, '{8'd32, 8'd27, 1'b0, 1'b0},
    '{8'd32, 8'd2,  1'b0, 1'b0}, '{8'd32, 8'd2,  1'b0, 1'b0},
    '{8'd32, 8'd2,  1'b0, 1'b0}, '{8'd32, 8'd2,  1'b0, 1'b0},
    '{8'd32, 8'd2,  1'b0, 1'b0}, '{8'd32, 8'd2,  1'b0, 1'b0},
    '{8'd64, 8'd5,  1'b0, 1'b0}, '{8'd64, 8'd5,  1'b1, 1'b0},
    '{8'd64, 8'd20, 1'b1, 1'b0}, '{8'd64, 8'd5,  1'b1, 1'b0},
    '{8'd64, 8'd27, 1'b1, 1'b0}, '{8'd64, 8'd27, 1'b1, 1'b1},
    '{8'd40, 8'd5,  1'b1, 1'b0}, '{8'd64, 8'd5,  1'b0, 1'b0},
    '{8'd70, 8'd5,  1'b1, 1'b0}, '{8'd64, 8'd5,  1'b1, 1'b0},
    '{8'd71, 8'd5,  1'b1, 1'b0}, '{8'd64, 8'd5,  1'b0, 1'b0},
    '{8'd64, 8'd16, 1'b1, 1'b0}, '{8'd32, 8'd16, 1'b1, 1'b0},
    '{8'd32, 8'd17, 1'b0, 1'b0}, '{8'd32, 8'd17, 1'b0, 1'b1},
    '{8'd64, 8'd5,  1'b0, 1'b0}, '{8'd64, 8'd5,  1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic forceLocal = 1'b0;
  logic refSyncN = 1'b1;
  logic genlockMode, hPhaseStrobe, vResetStrobe;

  int checks = 0;
  int fails = 0;
  int hSeen = 0;
  int vSeen = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  genlock_source_select #(
    .LINE_CYC(LINE), .LOSS_LINES(4), .LOCK_EDGES(8), .HOLD_CYC(HOLD)
  ) dut (
    .clk(clk), .rstN(rstN), .forceLocal(forceLocal), .refSyncN(refSyncN),
    .genlockMode(genlockMode), .hPhaseStrobe(hPhaseStrobe), .vResetStrobe(vResetStrobe)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One reference pulse: low for 'low' cycles, period 'period'; strobes counted
  task automatic pulse(input int period, input int low);
    hSeen = 0;
    vSeen = 0;
    for (int i = 0; i < period; i++) begin
      @(negedge clk);
      if (hPhaseStrobe) hSeen++;
      if (vResetStrobe) vSeen++;
      refSyncN = (i < low) ? 1'b0 : 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      refSyncN = 1'b1;
    end
  endtask

  initial begin
    int hTotal;
    // R1: reset state
    idle(3);
    chk("R1 mode in reset", int'(genlockMode), 0);
    chk("R1 strobes in reset", int'(hPhaseStrobe | vResetStrobe), 0);
    rstN = 1'b1;
    idle(2);
    chk("R1 mode after reset", int'(genlockMode), 0);

    // R2/R4: lock on line-spaced edges; the lock edge gives no strobe
    hTotal = 0;
    for (int p = 0; p < 8; p++) begin
      pulse(LINE, 5);
      hTotal += hSeen;
    end
    chk("R2 not locked after 8 pulses", int'(genlockMode), 0);
    pulse(LINE, 5);
    hTotal += hSeen;
    chk("R2 locked after 9th pulse", int'(genlockMode), 1);
    chk("R4 no strobe while locking", hTotal, 0);

    // Vector table: R4 horizontal strobes, R6/R7 broad pulses and vertical reset
    for (int k = 0; k < 38; k++) begin
      pulse(int'(VECS[k].period), int'(VECS[k].low));
      chk($sformatf("R4 hstrobe vector %0d", k), hSeen, int'(VECS[k].expH));
      chk($sformatf("R6 R7 vstrobe vector %0d", k), vSeen, int'(VECS[k].expV));
    end

    // R5: loss of reference, then hold-off; last fall was at the last vector's start
    idle(LOSS + HOLD - 3 - 63);
    chk("R5 mode held during hold-off", int'(genlockMode), 1);
    idle(6);
    chk("R5 mode reverted after hold-off", int'(genlockMode), 0);

    // R2: bad spacing restarts the count; half-line edges also lock
    for (int p = 0; p < 5; p++) pulse(LINE / 2, 2);
    pulse(45, 2);
    for (int p = 0; p < 8; p++) pulse(LINE / 2, 2);
    chk("R2 count restarted by bad gap", int'(genlockMode), 0);
    pulse(LINE / 2, 2);
    chk("R2 locked on half-line edges", int'(genlockMode), 1);

    // R3/R8: force stand-alone
    @(negedge clk);
    forceLocal = 1'b1;
    hTotal = 0;
    for (int p = 0; p < 3; p++) begin
      pulse(LINE, 5);
      hTotal += hSeen + vSeen;
    end
    chk("R3 mode forced local", int'(genlockMode), 0);
    chk("R8 no strobe in stand-alone", hTotal, 0);
    forceLocal = 1'b0;
    for (int p = 0; p < 9; p++) pulse(LINE, 5);
    chk("R3 relock after release", int'(genlockMode), 1);
    chk("R4 strobe after relock", hSeen, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule